// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a 32-bit countdown timer behind a small word-addressed register bus. Software writes a start value, picks a clock divider and turns counting on. The counter then steps down by one every (divider + 1) clock cycles. When it reaches zero it sets a sticky expiry flag and, depending on a mode bit, either reloads itself from the stored start value or stops at zero.

A level interrupt is raised while the expiry flag is set and the interrupt is unmasked. For a one-shot timeout, software first clears the flag and then writes a new start value. Writing the start value also restarts the countdown. This order keeps a short timeout from being lost.

The bus is a plain single-cycle register port. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr`, so there is no handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `cdown_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: `bus_addr[3:2]` selects the register and `bus_addr[1:0]` is ignored: 0 is the start value, 1 the live count, 2 control, 3 status. Control bit 0 enables counting, bit 1 selects reload mode, bit 2 unmasks the interrupt and bits 15:8 hold the divider; all other control bits read zero. Status bit 0 is the expiry flag and the other status bits read zero.
- R3: While counting is enabled with divider P, the count decreases by exactly one every P+1 cycles. Counting from the edge that enables it, or from the edge that writes the start value, the first decrement falls on edge P+1.
- R4: While counting is disabled, the count holds its value and the divider phase returns to zero.
- R5: Writing the start value copies it into the live count and restarts the divider phase.
- R6: Writing the live count replaces it directly. Software writes win over a decrement in the same cycle.
- R7: With reload mode off, a decrement from 1 to 0 sets the expiry flag once. The count then stays at zero and raises no further expiry.
- R8: With reload mode on, the step after the count reaches zero reloads it from the start value.
- R9: A start value of zero with counting enabled sets the expiry flag on the first divided step.
- R10: Writing status with bit 0 set clears the flag. Writing it with bit 0 clear has no effect. An expiry in the same cycle as a clear wins.
- R11: `irq` is high exactly when the expiry flag is set and the interrupt is unmasked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 4 | Byte address inside the 16-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that bus writes last exactly one cycle and change only between clock edges. They also assume that a divider step and a software write of the count never both move the counter, since the write takes priority. The bench changes the bus only on falling edges and holds each write strobe for a single rising edge. It stops counting and clears the flag before each new timed trial, so every expected count follows from the start value, the divider and the number of edges since enabling.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int ADDR_W  = 4;   // 16-byte register window
  localparam int PSC_LSB = 8;   // divider field position in control

  typedef enum logic [1:0] {
    SEL_START  = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic unmask;
    logic reload;
    logic run;
  } ctrl_flags_t;
endpackage

// File: rtl/cdt_prescale.sv
`timescale 1ns/1ps
module cdt_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] divider,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  // >= keeps the phase bounded if the divider is lowered mid-run
  assign tick = run && (phase_q >= divider);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= '0;
    else if (!run || restart)  phase_q <= '0;
    else if (tick)             phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic             wr_start,
  input  logic             wr_count,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] start_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             fresh_q;   // start value written, no step taken yet
  logic             at_zero;
  logic             step;

  assign at_zero = (count_q == '0);
  assign step    = tick && !wr_start && !wr_count;
  assign expire  = step && ((count_q == ONE) ||
                            (at_zero && (fresh_q || (reload && start_val == '0))));
  assign count   = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      fresh_q <= 1'b0;
    end else if (wr_start) begin
      count_q <= wr_val;
      fresh_q <= 1'b1;
    end else if (wr_count) begin
      count_q <= wr_val;
    end else if (tick) begin
      fresh_q <= 1'b0;
      if (!at_zero)    count_q <= count_q - ONE;
      else if (reload) count_q <= start_val;
    end
  end
endmodule

// File: rtl/cdt_regs.sv
`timescale 1ns/1ps
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [DATA_W-1:0]   count,
  input  logic                expire,
  output ctrl_flags_t         flags,
  output logic [PSC_W-1:0]    divider,
  output logic [DATA_W-1:0]   start_val,
  output logic                wr_start,
  output logic                wr_count,
  output logic                evt
);
  reg_sel_e    sel;
  logic        wr_hit;
  logic        wr_ctrl;
  logic        clr_evt;
  ctrl_flags_t flags_q;
  logic [PSC_W-1:0]  div_q;
  logic [DATA_W-1:0] start_q;
  logic        evt_q;

  assign sel      = reg_sel_e'(bus_addr[ADDR_W-1:2]);
  assign wr_hit   = bus_sel && bus_wr;
  assign wr_start = wr_hit && (sel == SEL_START);
  assign wr_count = wr_hit && (sel == SEL_COUNT);
  assign wr_ctrl  = wr_hit && (sel == SEL_CTRL);
  assign clr_evt  = wr_hit && (sel == SEL_STATUS) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      div_q   <= '0;
      start_q <= '0;
    end else begin
      if (wr_ctrl) begin
        flags_q.run    <= bus_wdata[0];
        flags_q.reload <= bus_wdata[1];
        flags_q.unmask <= bus_wdata[2];
        div_q          <= bus_wdata[PSC_LSB +: PSC_W];
      end
      if (wr_start) start_q <= bus_wdata;
    end
  end

  // expiry has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_q <= 1'b0;
    else if (expire)  evt_q <= 1'b1;
    else if (clr_evt) evt_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_START:  bus_rdata = start_q;
      SEL_COUNT:  bus_rdata = count;
      SEL_CTRL: begin
        bus_rdata[0] = flags_q.run;
        bus_rdata[1] = flags_q.reload;
        bus_rdata[2] = flags_q.unmask;
        bus_rdata[PSC_LSB +: PSC_W] = div_q;
      end
      SEL_STATUS: bus_rdata[0] = evt_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign flags     = flags_q;
  assign divider   = div_q;
  assign start_val = start_q;
  assign evt       = evt_q;
endmodule

// File: rtl/cdown_timer.sv
`timescale 1ns/1ps
module cdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PSC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  ctrl_flags_t       flags;
  logic [PSC_W-1:0]  divider;
  logic [DATA_W-1:0] start_val;
  logic [DATA_W-1:0] count_w;
  logic              wr_start, wr_count, tick, expire, evt_w;
  logic              run_w, reload_w;

  assign run_w    = flags.run;
  assign reload_w = flags.reload;

  cdt_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count_w), .expire(expire),
    .flags(flags), .divider(divider), .start_val(start_val),
    .wr_start(wr_start), .wr_count(wr_count), .evt(evt_w)
  );

  cdt_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_w), .restart(wr_start),
    .divider(divider), .tick(tick)
  );

  cdt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload_w),
    .wr_start(wr_start), .wr_count(wr_count), .wr_val(bus_wdata),
    .start_val(start_val), .count(count_w), .expire(expire)
  );

  assign irq = evt_w && flags.unmask;
endmodule

// File: rtl/cdown_timer_chk.sv
`timescale 1ns/1ps
module cdown_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] count,
  input logic              evt,
  input logic              run,
  input logic              reload
);
  logic w_start, w_count, w_clear;
  assign w_start = bus_sel && bus_wr && (bus_addr[3:2] == 2'd0);
  assign w_count = bus_sel && bus_wr && (bus_addr[3:2] == 2'd1);
  assign w_clear = bus_sel && bus_wr && (bus_addr[3:2] == 2'd3) && bus_wdata[0];

  // R5
  start_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_start |=> (count == $past(bus_wdata)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !w_start && !w_count) |=> $stable(count));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_start && !w_count && count != '0) |=>
      (count == $past(count) || count == $past(count) - 1'b1));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_start && !w_count && count == '0 && !reload) |=> (count == '0));

  // R10
  sticky_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !w_clear) |=> evt);
endmodule

bind cdown_timer cdown_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .count(count_w),
  .evt(evt_w), .run(run_w), .reload(reload_w)
);

// File: tb/cdown_timer_test.sv
`timescale 1ns/1ps
module cdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;   // 125 MHz

  cdown_timer uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
                   .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                   .bus_rdata(bus_rdata), .irq(irq));

  localparam logic [3:0] A_START = 4'h0, A_COUNT = 4'h4, A_CTRL = 4'h8, A_STAT = 4'hC;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl_word(input bit run, input bit rl, input bit um, input int p);
    return {16'h0, 8'(p), 5'h0, um, rl, run};
  endfunction

  // expected count after k edges from enabling, start n, divider p
  function automatic logic [31:0] exp_count(input int n, input int p, input int k, input bit rl);
    int t = k / (p + 1);
    if (t <= n) return 32'(n - t);
    if (!rl) return 32'd0;
    return 32'(n - ((t - n - 1) % (n + 1)));
  endfunction

  function automatic logic [31:0] exp_evt(input int n, input int p, input int k);
    return (k / (p + 1) >= n) ? 32'd1 : 32'd0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_START, d); check("R1 start", d, 0);
    rd(A_COUNT, d); check("R1 count", d, 0);
    rd(A_CTRL, d);  check("R1 ctrl", d, 0);
    rd(A_STAT, d);  check("R1 status", d, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 field layout, low address bits ignored
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(4'hB, d); check("R2 ctrl fields", d, 32'h0000_FF06);
    wr(A_CTRL, 0);
    wr(4'h3, 32'hA5A5_1234);
    rd(A_START, d); check("R2 start readback", d, 32'hA5A5_1234);
    rd(A_COUNT, d); check("R5 start copied to count", d, 32'hA5A5_1234);
    rd(A_STAT, d); check("R2 status upper bits", d, 0);

    // R3 divider 3, start 10
    wr(A_START, 10);
    wr(A_CTRL, ctrl_word(1, 0, 0, 3));
    edges(3); rd(A_COUNT, d); check("R3 before first step", d, 10);
    edges(1); rd(A_COUNT, d); check("R3 first step on edge P+1", d, 9);
    // R4 disable holds
    wr(A_CTRL, ctrl_word(0, 0, 0, 3));
    edges(20); rd(A_COUNT, d); check("R4 hold while disabled", d, 9);

    // R6 direct count write, then R7 one-shot expiry
    wr(A_COUNT, 5);
    rd(A_COUNT, d); check("R6 count write", d, 5);
    wr(A_CTRL, ctrl_word(1, 0, 0, 0));
    edges(3); rd(A_COUNT, d); check("R6 count after 3 steps", d, 2);
    rd(A_STAT, d); check("R7 no event yet", d, 0);
    edges(2); rd(A_STAT, d); check("R7 event at zero", d, 1);
    check("R11 masked irq low", {31'b0, irq}, 0);
    edges(10); rd(A_COUNT, d); check("R7 holds at zero", d, 0);
    wr(A_STAT, 1); rd(A_STAT, d); check("R10 clear", d, 0);
    edges(10); rd(A_STAT, d); check("R7 no repeat expiry", d, 0);

    // R9 zero start, R11 gating, R10 write-zero ignored
    wr(A_CTRL, 0); wr(A_STAT, 1);
    wr(A_START, 0);
    wr(A_CTRL, ctrl_word(1, 0, 1, 2));
    edges(2); rd(A_STAT, d); check("R9 not before first step", d, 0);
    check("R11 irq low", {31'b0, irq}, 0);
    edges(1); rd(A_STAT, d); check("R9 event on first step", d, 1);
    check("R11 irq high", {31'b0, irq}, 1);
    wr(A_CTRL, ctrl_word(1, 0, 0, 2));
    check("R11 irq masked", {31'b0, irq}, 0);
    wr(A_STAT, 32'hFFFF_FFFE); rd(A_STAT, d); check("R10 write of 0 ignored", d, 1);
    wr(A_STAT, 1); rd(A_STAT, d); check("R10 clear again", d, 0);

    // R8 reload
    wr(A_CTRL, 0); wr(A_STAT, 1);
    wr(A_START, 3);
    wr(A_CTRL, ctrl_word(1, 1, 0, 0));
    edges(3); rd(A_COUNT, d); check("R8 reached zero", d, 0);
    edges(1); rd(A_COUNT, d); check("R8 reloaded", d, 3);
    edges(3); rd(A_COUNT, d); check("R8 zero again", d, 0);

    // R5 restart mid-run
    wr(A_CTRL, 0); wr(A_STAT, 1);
    wr(A_START, 20);
    wr(A_CTRL, ctrl_word(1, 0, 0, 1));
    edges(7);
    wr(A_START, 12);
    edges(5); rd(A_COUNT, d); check("R5 restart count", d, 10);

    // random trials, R3 R7 R8
    for (int i = 0; i < 40; i++) begin
      int n  = 1 + int'($urandom_range(11, 0));
      int p  = int'($urandom_range(3, 0));
      bit rl = 1'($urandom_range(1, 0));
      int k  = int'($urandom_range(2 * (n + 1) * (p + 1) + 3, 0));
      wr(A_CTRL, 0); wr(A_STAT, 1);
      wr(A_START, 32'(n));
      wr(A_CTRL, ctrl_word(1, rl, 0, p));
      edges(k);
      rd(A_COUNT, d); check(rl ? "R8 random count" : "R3 random count", d, exp_count(n, p, k, rl));
      rd(A_STAT, d);  check("R7 random event", d, exp_evt(n, p, k));
    end

    finish_run();
  end
endmodule